// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a test access port that runs entirely on the test clock `tck`. A 16-state controller walks the standard IEEE 1149.1 state graph under `tms`. The controller routes serial data from `tdi` to `tdo` through one of two paths. The first is a 4-bit instruction register. The second is one of four data registers: a one-stage bypass, a 32-bit identification word, a one-bit device-reset register, and a boundary chain wrapped around `N_PINS` device pins. Each pin has three cells: one for the pad input, one for the output value and one for the output enable.

The instruction set has five entries:
- **Boundary drive:** while active, the boundary latches own the pads, starting in the cycle after Update-IR.
- **Sample/preload:** takes a snapshot of the pins and loads the latches, and the pins keep working normally.
- **Identification:** selects the identification word.
- **Bypass:** selects the one-stage bypass.
- **Device reset:** a scanned 1 holds the rest of the device in reset, and while the device is in reset its pads float.

Two inputs gate the whole port: a fuse-style enable and a disable bit. When the port is gated, `tdo` is not driven and the controller sits in Test-Logic-Reset.

Top module: `scan_tap`

## Requirements
- R1: `tms` is sampled on the rising edge of `tck`. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. A synchronous active-high `rst` sampled on `tck` does the same.
- R2: The port is active only while `tap_fuse_ok` is 1 and `tap_disable` is 0. Otherwise `tdo_oe` is 0 and the controller is held in Test-Logic-Reset, so after re-enabling the identification word is selected.
- R3: The instruction register is 4 bits. It loads 4'b0001 in Capture-IR and takes effect in Update-IR. The opcodes are:
  - boundary drive = 0x0
  - identification = 0x1
  - sample/preload = 0x2
  - device reset = 0xC
  - bypass = 0xF
  - every other opcode selects the bypass stage.
- R4: In Test-Logic-Reset the active instruction becomes identification.
- R5: The identification word is {version[31:28], part number[27:12], maker code[11:1], 1'b1}.
- R6: The version field equals `REVISION` modulo 16.
- R7: The bypass stage loads 0 in Capture-DR and delays `tdi` by one shift.
- R8: Every scan path shifts toward `tdo` with bit 0 first, and `tdi` enters at the top bit. `tdo` and `tdo_oe` change on the falling edge of `tck`, and `tdo_oe` is 1 only in Shift-IR and Shift-DR.
- R9: The boundary chain has 3*`N_PINS` bits. Cell 3p captures `pin_in[p]`, cell 3p+1 captures `core_out[p]` and cell 3p+2 captures `core_oe[p]`. Outside boundary drive, `pad_out` follows `core_out` and `pad_oe` follows `core_oe`.
- R10: Update-DR under sample/preload or boundary drive loads the latches. From the cycle after Update-IR of boundary drive, `pad_out[p]` and `pad_oe[p]` show latch cells 3p+1 and 3p+2. Update-DR under other instructions leaves the latches unchanged.
- R11: Update-DR under device reset loads the reset bit from the scanned bit, and Capture-DR reads the bit back. `dev_rst_req` is 1 while device reset is active and the bit is 1. The bit is cleared in Test-Logic-Reset.
- R12: While `dev_rst_req` or `core_in_reset` is 1 and boundary drive is not active, every `pad_oe` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high port reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| tdo | output | 1 | Serial data out, falling-edge register |
| tdo_oe | output | 1 | Drive enable for `tdo` |
| tap_fuse_ok | input | 1 | Fuse-style port enable |
| tap_disable | input | 1 | Control bit that disables the port |
| pin_in | input | N_PINS | Values seen at the pads |
| core_out | input | N_PINS | Functional output values from the device |
| core_oe | input | N_PINS | Functional output enables from the device |
| core_in_reset | input | 1 | Device is in reset from another source |
| pad_out | output | N_PINS | Output value sent to the pads |
| pad_oe | output | N_PINS | Output enable sent to the pads |
| dev_rst_req | output | 1 | Reset request to the rest of the device |

## Verification
Inputs change 1 ns after a falling edge, and `tdo` is read at that same moment. The value read is therefore the bit that leaves on the next rising edge. The first shifted bit is the one captured on the edge that entered Shift-IR or Shift-DR.

Instruction effects appear on the pads and on `dev_rst_req` right after the rising edge taken in Update-IR. Latch effects appear right after the rising edge taken in Update-DR. The bench checks 1 ns after the scan task returns from that edge.

Expected words, snapshots and pad values come from bench functions written from the field layouts above. Random pin patterns and random `tms` walks are mixed with directed cases.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    SEL_BYPASS, SEL_IDCODE, SEL_BOUNDARY, SEL_DEVRST
  } dr_sel_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'h0;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'h1;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'h2;
  localparam logic [IR_W-1:0] OP_DEVRST  = 4'hC;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  // Map an opcode to the data register it places between tdi and tdo.
  function automatic dr_sel_e decode_op(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLE: return SEL_BOUNDARY;
      OP_IDCODE:            return SEL_IDCODE;
      OP_DEVRST:            return SEL_DEVRST;
      default:              return SEL_BYPASS;
    endcase
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       port_en,
  input  logic       tms,
  output tap_state_e state_q,
  output logic       in_tlr,
  output logic       cap_dr,
  output logic       sh_dr,
  output logic       upd_dr,
  output logic       cap_ir,
  output logic       sh_ir,
  output logic       upd_ir
);

  tap_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  // A gated port is parked in Test-Logic-Reset, the same as a reset.
  always_ff @(posedge tck) begin
    if (rst || !port_en) state_q <= ST_TLR;
    else                 state_q <= state_d;
  end

  assign in_tlr = (state_q == ST_TLR);
  assign cap_dr = (state_q == ST_CAP_DR);
  assign sh_dr  = (state_q == ST_SH_DR);
  assign upd_dr = (state_q == ST_UPD_DR);
  assign cap_ir = (state_q == ST_CAP_IR);
  assign sh_ir  = (state_q == ST_SH_IR);
  assign upd_ir = (state_q == ST_UPD_IR);

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst,
  input  logic            tdi,
  input  logic            in_tlr,
  input  logic            cap_en,
  input  logic            sh_en,
  input  logic            upd_en,
  output logic [IR_W-1:0] active_op,
  output logic            ir_tdo
);

  logic [IR_W-1:0] sr_q;

  always_ff @(posedge tck) begin
    if (rst || in_tlr) begin
      sr_q      <= IR_CAPTURE;
      active_op <= OP_IDCODE;
    end else begin
      if (cap_en)     sr_q <= IR_CAPTURE;
      else if (sh_en) sr_q <= {tdi, sr_q[IR_W-1:1]};
      if (upd_en)     active_op <= sr_q;
    end
  end

  assign ir_tdo = sr_q[0];

endmodule

// File: rtl/scan_tap_bsr.sv
module scan_tap_bsr #(
  parameter int N_PINS = 4
) (
  input  logic              tck,
  input  logic              rst,
  input  logic              tdi,
  input  logic              cap_en,
  input  logic              sh_en,
  input  logic              upd_en,
  input  logic              drive_pins,
  input  logic              hold_hiz,
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] core_out,
  input  logic [N_PINS-1:0] core_oe,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  output logic              chain_tdo
);

  localparam int CELLS_PER_PIN = 3;
  localparam int CHAIN_LEN     = CELLS_PER_PIN * N_PINS;

  logic [CHAIN_LEN-1:0] snap;
  logic [CHAIN_LEN-1:0] shift_q;
  logic [N_PINS-1:0]    lat_out_q;
  logic [N_PINS-1:0]    lat_oe_q;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    assign snap[CELLS_PER_PIN*p]     = pin_in[p];
    assign snap[CELLS_PER_PIN*p + 1] = core_out[p];
    assign snap[CELLS_PER_PIN*p + 2] = core_oe[p];

    always_ff @(posedge tck) begin
      if (rst) begin
        lat_out_q[p] <= 1'b0;
        lat_oe_q[p]  <= 1'b0;
      end else if (upd_en) begin
        lat_out_q[p] <= shift_q[CELLS_PER_PIN*p + 1];
        lat_oe_q[p]  <= shift_q[CELLS_PER_PIN*p + 2];
      end
    end

    // Pad mux: boundary latches win, then the reset float, then the core.
    assign pad_out[p] = drive_pins ? lat_out_q[p] : core_out[p];
    assign pad_oe[p]  = drive_pins ? lat_oe_q[p]  : (core_oe[p] & ~hold_hiz);
  end

  always_ff @(posedge tck) begin
    if (rst)         shift_q <= '0;
    else if (cap_en) shift_q <= snap;
    else if (sh_en)  shift_q <= {tdi, shift_q[CHAIN_LEN-1:1]};
  end

  assign chain_tdo = shift_q[0];

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int          N_PINS   = 4,
  parameter int          REVISION = 18,
  parameter logic [15:0] PART_NUM = 16'hA5C3,
  parameter logic [10:0] MAKER_ID = 11'h0B7
) (
  input  logic              tck,
  input  logic              rst,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  input  logic              tap_fuse_ok,
  input  logic              tap_disable,
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] core_out,
  input  logic [N_PINS-1:0] core_oe,
  input  logic              core_in_reset,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  output logic              dev_rst_req
);

  localparam int             ID_W    = 32;
  localparam logic [3:0]     VERSION = 4'(REVISION % 16);
  localparam logic [ID_W-1:0] ID_WORD = {VERSION, PART_NUM, MAKER_ID, 1'b1};

  logic port_en;
  assign port_en = tap_fuse_ok & ~tap_disable;

  tap_state_e state_q;
  logic in_tlr, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;

  scan_tap_fsm u_fsm (
    .tck     (tck),
    .rst     (rst),
    .port_en (port_en),
    .tms     (tms),
    .state_q (state_q),
    .in_tlr  (in_tlr),
    .cap_dr  (cap_dr),
    .sh_dr   (sh_dr),
    .upd_dr  (upd_dr),
    .cap_ir  (cap_ir),
    .sh_ir   (sh_ir),
    .upd_ir  (upd_ir)
  );

  logic [IR_W-1:0] ir_op;
  logic            ir_tdo;

  scan_tap_ir u_ir (
    .tck       (tck),
    .rst       (rst),
    .tdi       (tdi),
    .in_tlr    (in_tlr),
    .cap_en    (cap_ir),
    .sh_en     (sh_ir),
    .upd_en    (upd_ir),
    .active_op (ir_op),
    .ir_tdo    (ir_tdo)
  );

  dr_sel_e dr_sel;
  assign dr_sel = decode_op(ir_op);

  // Bypass stage
  logic byp_q;
  always_ff @(posedge tck) begin
    if (rst)                                  byp_q <= 1'b0;
    else if (cap_dr && dr_sel == SEL_BYPASS)  byp_q <= 1'b0;
    else if (sh_dr && dr_sel == SEL_BYPASS)   byp_q <= tdi;
  end

  // Identification word
  logic [ID_W-1:0] id_q;
  always_ff @(posedge tck) begin
    if (rst)                                  id_q <= ID_WORD;
    else if (cap_dr && dr_sel == SEL_IDCODE)  id_q <= ID_WORD;
    else if (sh_dr && dr_sel == SEL_IDCODE)   id_q <= {tdi, id_q[ID_W-1:1]};
  end

  // Device-reset register: one shift stage plus the held bit
  logic rsr_q, rlat_q;
  always_ff @(posedge tck) begin
    if (rst || in_tlr) begin
      rsr_q  <= 1'b0;
      rlat_q <= 1'b0;
    end else begin
      if (cap_dr && dr_sel == SEL_DEVRST)      rsr_q <= rlat_q;
      else if (sh_dr && dr_sel == SEL_DEVRST)  rsr_q <= tdi;
      if (upd_dr && dr_sel == SEL_DEVRST)      rlat_q <= rsr_q;
    end
  end

  assign dev_rst_req = (ir_op == OP_DEVRST) && rlat_q;

  // Boundary chain
  logic chain_tdo;
  logic sel_chain;
  assign sel_chain = (dr_sel == SEL_BOUNDARY);

  scan_tap_bsr #(.N_PINS(N_PINS)) u_bsr (
    .tck        (tck),
    .rst        (rst),
    .tdi        (tdi),
    .cap_en     (cap_dr & sel_chain),
    .sh_en      (sh_dr & sel_chain),
    .upd_en     (upd_dr & sel_chain),
    .drive_pins (ir_op == OP_EXTEST),
    .hold_hiz   (core_in_reset | dev_rst_req),
    .pin_in     (pin_in),
    .core_out   (core_out),
    .core_oe    (core_oe),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .chain_tdo  (chain_tdo)
  );

  // Serial output: selected path, registered on the falling edge
  logic dr_tdo;
  always_comb begin
    case (dr_sel)
      SEL_IDCODE:   dr_tdo = id_q[0];
      SEL_BOUNDARY: dr_tdo = chain_tdo;
      SEL_DEVRST:   dr_tdo = rsr_q;
      default:      dr_tdo = byp_q;
    endcase
  end

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= sh_ir ? ir_tdo : dr_tdo;
      tdo_oe <= port_en & (sh_ir | sh_dr);
    end
  end

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
#(
  parameter int N_PINS = 4
) (
  input logic              tck,
  input logic              rst,
  input logic              tms,
  input logic              port_en,
  input tap_state_e        state,
  input logic [IR_W-1:0]   ir_op,
  input logic              tdo_oe,
  input logic              dev_rst_req,
  input logic              hold_src,
  input logic [N_PINS-1:0] pad_oe
);

  logic [2:0] ones_q;
  always_ff @(posedge tck) begin
    if (rst || !tms)          ones_q <= 3'd0;
    else if (ones_q != 3'd5)  ones_q <= ones_q + 3'd1;
  end

  AST_FIVE_ONES_TLR: assert property (@(posedge tck) disable iff (rst)
    ones_q == 3'd5 |-> state == ST_TLR);                                      // R1
  AST_GATED_PARKED: assert property (@(posedge tck) disable iff (rst)
    !port_en |=> state == ST_TLR);                                            // R2
  AST_IR_STEADY: assert property (@(posedge tck) disable iff (rst)
    (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir_op));              // R3
  AST_TLR_IDCODE: assert property (@(posedge tck) disable iff (rst)
    state == ST_TLR |=> ir_op == OP_IDCODE);                                  // R4
  AST_TDO_DRIVE_SHIFT: assert property (@(posedge tck) disable iff (rst)
    tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));                     // R8
  AST_RSTREQ_ON_UPDATE: assert property (@(posedge tck) disable iff (rst)
    $rose(dev_rst_req) |-> ($past(state) == ST_UPD_DR || $past(state) == ST_UPD_IR)); // R11
  AST_PADS_FLOAT: assert property (@(posedge tck) disable iff (rst)
    ((hold_src || dev_rst_req) && ir_op != OP_EXTEST) |-> pad_oe == '0);      // R12

endmodule

bind scan_tap scan_tap_chk #(.N_PINS(N_PINS)) u_chk (
  .tck         (tck),
  .rst         (rst),
  .tms         (tms),
  .port_en     (port_en),
  .state       (state_q),
  .ir_op       (ir_op),
  .tdo_oe      (tdo_oe),
  .dev_rst_req (dev_rst_req),
  .hold_src    (core_in_reset),
  .pad_oe      (pad_oe)
);

// File: tb/scan_tap_test.sv
module scan_tap_test;
  localparam int          NP  = 4;
  localparam int          BL  = 3 * NP;
  localparam int          REV = 18;
  localparam logic [15:0] PN  = 16'hA5C3;
  localparam logic [10:0] MF  = 11'h0B7;

  logic tck = 1'b0, rst = 1'b1, tms = 1'b0, tdi = 1'b0;
  logic tap_fuse_ok = 1'b1, tap_disable = 1'b0, core_in_reset = 1'b0;
  logic [NP-1:0] pin_in = '0, core_out = '0, core_oe = '0;
  wire tdo, tdo_oe, dev_rst_req;
  wire [NP-1:0] pad_out, pad_oe;
  int n_chk = 0, n_bad = 0;

  always #4 tck = ~tck;

  scan_tap #(.N_PINS(NP), .REVISION(REV), .PART_NUM(PN), .MAKER_ID(MF)) uut (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .tap_fuse_ok(tap_fuse_ok), .tap_disable(tap_disable),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .core_in_reset(core_in_reset), .pad_out(pad_out), .pad_oe(pad_oe),
    .dev_rst_req(dev_rst_req));

  function automatic logic [31:0] id_exp();
    logic [3:0] v = 4'(REV % 16);
    return {v, PN, MF, 1'b1};
  endfunction

  function automatic logic [63:0] snap_exp(logic [NP-1:0] pi, logic [NP-1:0] co, logic [NP-1:0] ce);
    logic [63:0] v = '0;
    for (int p = 0; p < NP; p++) begin
      v[3*p] = pi[p]; v[3*p+1] = co[p]; v[3*p+2] = ce[p];
    end
    return v;
  endfunction

  function automatic logic [NP-1:0] lat_out(logic [63:0] q);
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) r[p] = q[3*p+1];
    return r;
  endfunction

  function automatic logic [NP-1:0] lat_oe(logic [63:0] q);
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) r[p] = q[3*p+2];
    return r;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // One TCK cycle: drive after the falling edge, read tdo there, return at the rising edge.
  task automatic step(input logic m, input logic d, output logic o, output logic e);
    @(negedge tck); #1;
    tms = m; tdi = d; o = tdo; e = tdo_oe;
    @(posedge tck);
  endtask

  task automatic reset_tap();
    logic o, e;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o, e);
    step(1'b0, 1'b0, o, e);
  endtask

  task automatic shift_dr(input logic [63:0] din, input int len, output logic [63:0] dout, output logic oe_ok);
    logic o, e;
    dout = '0; oe_ok = 1'b1;
    step(1'b1, 1'b0, o, e); step(1'b0, 1'b0, o, e); step(1'b0, 1'b0, o, e);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, din[i], o, e);
      dout[i] = o;
      if (!e) oe_ok = 1'b0;
    end
    step(1'b1, 1'b0, o, e); if (e) oe_ok = 1'b0;
    step(1'b0, 1'b0, o, e);
    #1;
  endtask

  task automatic shift_ir(input logic [3:0] op, output logic [3:0] cap, output logic oe_ok);
    logic o, e;
    cap = '0; oe_ok = 1'b1;
    step(1'b1, 1'b0, o, e); step(1'b1, 1'b0, o, e);
    step(1'b0, 1'b0, o, e); step(1'b0, 1'b0, o, e);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], o, e);
      cap[i] = o;
      if (!e) oe_ok = 1'b0;
    end
    step(1'b1, 1'b0, o, e); if (e) oe_ok = 1'b0;
    step(1'b0, 1'b0, o, e);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [63:0] dout, d, q, q2;
    logic [3:0] irc;
    logic ok, o, e;
    void'($urandom(32'd2718));
    core_out = 4'b1010; core_oe = 4'b0110; pin_in = 4'b0011;
    repeat (3) @(posedge tck);
    @(negedge tck); rst = 1'b0;
    #1;
    check("R8", "tdo_oe after reset", 64'(tdo_oe), 64'd0);
    check("R11", "reset request after reset", 64'(dev_rst_req), 64'd0);
    check("R9", "pad_out follows core", 64'(pad_out), 64'(core_out));
    check("R9", "pad_oe follows core", 64'(pad_oe), 64'(core_oe));

    // Default path after reset is the identification word
    step(1'b0, 1'b0, o, e);
    shift_dr(64'h0, 32, dout, ok);
    check("R4", "default path word", dout, 64'(id_exp()));
    check("R5", "bit0 constant one", 64'(dout[0]), 64'd1);
    check("R6", "version field", 64'(dout[31:28]), 64'(REV % 16));
    check("R8", "tdo_oe during/after DR shift", 64'(ok), 64'd1);

    // Bypass and instruction capture
    shift_ir(4'hF, irc, ok);
    check("R3", "IR capture pattern", 64'(irc), 64'h1);
    check("R8", "tdo_oe during/after IR shift", 64'(ok), 64'd1);
    for (int k = 0; k < 3; k++) begin
      d = 64'($urandom) & 64'hFFFF;
      shift_dr(d, 16, dout, ok);
      check("R7", "bypass delay", dout & 64'hFFFF, {d[62:0], 1'b0} & 64'hFFFF);
    end
    shift_ir(4'h7, irc, ok);
    d = 64'hB5;
    shift_dr(d, 8, dout, ok);
    check("R3", "unassigned opcode acts as bypass", dout & 64'hFF, 64'h6A);

    // Sample/preload snapshots with random pins
    shift_ir(4'h2, irc, ok);
    q = '0;
    for (int k = 0; k < 6; k++) begin
      pin_in = NP'($urandom); core_out = NP'($urandom); core_oe = NP'($urandom);
      q = 64'($urandom) & ((64'd1 << BL) - 1);
      shift_dr(q, BL, dout, ok);
      check("R9", "sample snapshot", dout, snap_exp(pin_in, core_out, core_oe));
      check("R9", "pads normal under sample out", 64'(pad_out), 64'(core_out));
      check("R9", "pads normal under sample oe", 64'(pad_oe), 64'(core_oe));
    end

    // Boundary drive takes the preloaded latches at Update-IR
    shift_ir(4'h0, irc, ok);
    check("R10", "pad_out from preload", 64'(pad_out), 64'(lat_out(q)));
    check("R10", "pad_oe from preload", 64'(pad_oe), 64'(lat_oe(q)));
    q2 = 64'($urandom) & ((64'd1 << BL) - 1);
    shift_dr(q2, BL, dout, ok);
    check("R9", "capture under boundary drive", dout, snap_exp(pin_in, core_out, core_oe));
    check("R10", "pad_out after update", 64'(pad_out), 64'(lat_out(q2)));
    core_out = ~core_out; core_oe = ~core_oe; #1;
    check("R10", "core ignored in boundary drive", 64'(pad_oe), 64'(lat_oe(q2)));
    shift_ir(4'hF, irc, ok);
    check("R10", "pads back to core", 64'(pad_out), 64'(core_out));
    shift_dr(64'hFFF, BL, dout, ok);
    shift_ir(4'h0, irc, ok);
    check("R10", "latches kept across bypass update", 64'({pad_out, pad_oe}), 64'({lat_out(q2), lat_oe(q2)}));
    shift_ir(4'hF, irc, ok);

    // Device reset register
    core_oe = '1; #1;
    shift_ir(4'hC, irc, ok);
    check("R11", "no request with bit clear", 64'(dev_rst_req), 64'd0);
    shift_dr(64'h1, 1, dout, ok);
    check("R11", "readback of clear bit", 64'(dout[0]), 64'd0);
    check("R11", "request set", 64'(dev_rst_req), 64'd1);
    check("R12", "pads float in reset", 64'(pad_oe), 64'd0);
    check("R12", "pad_out still core", 64'(pad_out), 64'(core_out));
    shift_dr(64'h0, 1, dout, ok);
    check("R11", "readback of set bit", 64'(dout[0]), 64'd1);
    check("R11", "request cleared by scan", 64'(dev_rst_req), 64'd0);
    shift_dr(64'h1, 1, dout, ok);
    shift_ir(4'hF, irc, ok);
    check("R11", "request drops with instruction", 64'(dev_rst_req), 64'd0);
    check("R12", "pads back after request", 64'(pad_oe), 64'(core_oe));
    shift_ir(4'hC, irc, ok);
    check("R11", "held bit returns with instruction", 64'(dev_rst_req), 64'd1);
    reset_tap(); #1;
    check("R11", "bit cleared by TLR", 64'(dev_rst_req), 64'd0);

    // External reset source
    core_in_reset = 1'b1; #1;
    check("R12", "pads float on core reset", 64'(pad_oe), 64'd0);
    shift_ir(4'h0, irc, ok);
    check("R12", "boundary drive overrides float", 64'(pad_oe), 64'(lat_oe(q2)));
    shift_ir(4'hF, irc, ok);
    core_in_reset = 1'b0; #1;
    check("R12", "pads return after core reset", 64'(pad_oe), 64'(core_oe));

    // Random TMS walks, then five ones
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 20; j++) step(1'($urandom), 1'($urandom), o, e);
      reset_tap();
      shift_dr(64'h0, 32, dout, ok);
      check("R1", "five ones reach TLR", dout, 64'(id_exp()));
    end
    for (int j = 0; j < 13; j++) step(1'($urandom), 1'($urandom), o, e);
    @(negedge tck); rst = 1'b1; @(negedge tck); rst = 1'b0;
    step(1'b0, 1'b0, o, e);
    shift_dr(64'h0, 32, dout, ok);
    check("R1", "reset input reaches TLR", dout, 64'(id_exp()));

    // Gating the port
    for (int k = 0; k < 2; k++) begin
      shift_ir(4'hF, irc, ok);
      @(negedge tck);
      if (k == 0) tap_fuse_ok = 1'b0; else tap_disable = 1'b1;
      ok = 1'b1;
      step(1'b1, 1'b0, o, e); if (e) ok = 1'b0;
      step(1'b0, 1'b0, o, e); if (e) ok = 1'b0;
      for (int j = 0; j < 5; j++) begin step(1'b0, 1'b1, o, e); if (e) ok = 1'b0; end
      check("R2", "tdo not driven while gated", 64'(ok), 64'd1);
      @(negedge tck); tap_fuse_ok = 1'b1; tap_disable = 1'b0;
      step(1'b0, 1'b0, o, e);
      shift_dr(64'h0, 32, dout, ok);
      check("R2", "held in TLR while gated", dout, 64'(id_exp()));
    end

    summary();
  end
endmodule